// File: doc/BRIEF.md
# Triggered Digitizer Channel Capture

This block is the per-channel capture stage of a multi-channel flash digitizer. A new 10-bit conversion result arrives on every clock. Each result runs through a shift-register delay line of selectable length. Because of that delay, the recorded window can begin before the trigger arrived. When a trigger strobe is seen, the channel records a programmable number of consecutive delayed samples. It becomes busy for exactly that many clocks and ignores further triggers until it is done.

While the window is being recorded, a per-channel threshold suppresses small samples in real time. Only samples above the threshold are pushed into the channel FIFO. Each pushed word is tagged with its position inside the window, so the timing of sparse data can be rebuilt. A threshold of zero turns suppression off. If the FIFO fills, later words are lost and a sticky flag reports it. Two separate strobes exist: one empties the FIFO, and the other returns the threshold to its default.

Top module: `dig_capture_chan`

## Requirements
- R1: Window position i (counted from 0) holds the sample that was presented at the trigger clock edge plus i minus the delay setting, where the delay setting is `cfg_delay` clocks (0 to 127).
- R2: A capture covers exactly `cfg_count` window positions, taken when the trigger is accepted. A count of 0 means 1024 positions.
- R3: With a nonzero threshold, a sample is stored only if it is strictly greater than the threshold. A sample equal to the threshold is dropped.
- R4: With a threshold of 0, every sample in the window is stored.
- R5: Each FIFO word is 20 bits. Bits 19:10 hold the window position and bits 9:0 hold the sample.
- R6: `busy` is high for exactly N clocks, starting at the edge that accepts the trigger, where N is the window length. `done` is a one-clock pulse that is high in the first cycle with `busy` low after a capture.
- R7: A trigger that arrives while `busy` is high is ignored. The window is neither restarted nor extended.
- R8: When the FIFO holds `FIFO_DEPTH` words (default 64), further writes are dropped and `overflow` becomes 1. `overflow` stays 1 until a FIFO reset, even after the FIFO is read out.
- R9: A `fifo_reset` pulse empties the FIFO and clears `overflow`.
- R10: A `thr_reset` pulse sets the threshold back to `DEF_THRESH` (default 8). A `thr_wr` pulse loads `thr_data` as the threshold.
- R11: Words leave the FIFO in the order they were written. `rd_data` shows the oldest word whenever `rd_valid` is 1, and `rd_en` removes that word at the next clock edge.
- R12: After reset, `busy`, `done`, `overflow` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | 10 | Conversion result, one per clock |
| trig | input | 1 | Capture trigger strobe |
| cfg_delay | input | 7 | Delay-line length in clocks |
| cfg_count | input | 10 | Window length, 0 means 1024 |
| thr_wr | input | 1 | Load `thr_data` as the threshold |
| thr_data | input | 10 | New threshold value |
| thr_reset | input | 1 | Restore the default threshold |
| fifo_reset | input | 1 | Empty the FIFO and clear `overflow` |
| rd_en | input | 1 | Remove the head word |
| rd_data | output | 20 | Head word: position and sample |
| rd_valid | output | 1 | FIFO not empty |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-clock end-of-capture pulse |
| overflow | output | 1 | Sticky write-dropped flag |

## Verification
A wrong position counter or wrong delay tap shows up on the first word read out of the FIFO, because the position field or the sample value no longer matches the scoreboard. That mismatch is visible a few clocks after the trigger. A wrong window limit, or a trigger wrongly accepted while busy, shows up as a `busy` length different from the window length. It also shows up as extra or missing words once the FIFO is drained. A wrong threshold compare appears as a word that should have been suppressed, or as one that is missing. Damaged FIFO pointers or overflow state are caught when the queue is drained after a deliberate fill, and again after a FIFO reset.

// File: rtl/dcap_pkg.sv
// Shared widths and the stored word layout for the digitizer channel capture.
package dcap_pkg;
    localparam int SAMPLE_W = 10;
    localparam int IDX_W    = 10;
    localparam int WORD_W   = SAMPLE_W + IDX_W;

    // Stored word: window position in the upper field, sample in the lower.
    typedef struct packed {
        logic [IDX_W-1:0]    idx;
        logic [SAMPLE_W-1:0] smp;
    } cap_word_t;
endpackage

// File: rtl/dcap_delay.sv
// Selectable-length shift-register delay for raw samples.
// Assumes: DEPTH is a power of two; sel chooses a tap, so output equals the
// sample taken sel+1 edges ago (sel = 0 gives one register of latency).
module dcap_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 128,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout
);
    logic [W-1:0] stage [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                // Purpose: capture the newest sample.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= din;
                end
            end else begin : g_body
                // Purpose: move each sample one step deeper.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    // Purpose: select the configured tap.
    always_comb dout = stage[sel];
endmodule

// File: rtl/dcap_ctrl.sv
// Capture sequencer with threshold register and real-time suppression.
// Assumes: a trigger is accepted only when idle; the window length is latched
// at acceptance; a count of 0 stands for 2**IDX_W positions.
module dcap_ctrl
    import dcap_pkg::*;
#(
    parameter logic [SAMPLE_W-1:0] DEF_THRESH = 10'd8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig,
    input  logic [IDX_W-1:0]    cfg_count,
    input  logic                thr_wr,
    input  logic [SAMPLE_W-1:0] thr_data,
    input  logic                thr_reset,
    input  logic [SAMPLE_W-1:0] smp_dly,
    output logic                wr_en,
    output cap_word_t           wr_word,
    output logic                busy,
    output logic                done
);
    localparam logic [IDX_W:0] ONE  = (IDX_W+1)'(1);
    localparam logic [IDX_W:0] FULL = {1'b1, {IDX_W{1'b0}}};

    logic                busy_q, done_q;
    logic [IDX_W:0]      idx_q, lim_q;
    logic [SAMPLE_W-1:0] thr_q;

    // Purpose: run the window, ignoring triggers while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            lim_q  <= FULL;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && trig) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                lim_q  <= (cfg_count == '0) ? FULL : {1'b0, cfg_count};
            end else if (busy_q) begin
                idx_q <= idx_q + ONE;
                if (idx_q + ONE == lim_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Purpose: hold the threshold; a default restore wins over a load.
    always_ff @(posedge clk) begin
        if (!rst_n)         thr_q <= DEF_THRESH;
        else if (thr_reset) thr_q <= DEF_THRESH;
        else if (thr_wr)    thr_q <= thr_data;
    end

    // Purpose: suppress samples at or below a nonzero threshold.
    always_comb begin
        wr_en       = busy_q && ((thr_q == '0) || (smp_dly > thr_q));
        wr_word.idx = idx_q[IDX_W-1:0];
        wr_word.smp = smp_dly;
    end

    assign busy = busy_q;
    assign done = done_q;

    a_r7_retrig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (idx_q + ONE != lim_q)) |=> (busy_q && idx_q == $past(idx_q) + ONE));
    a_r2_idx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q < lim_q));
    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    a_r10_thr_default: assert property (@(posedge clk) disable iff (!rst_n)
        thr_reset |=> (thr_q == DEF_THRESH));
endmodule

// File: rtl/dcap_fifo.sv
// Channel FIFO with show-ahead read, drop-on-full and a sticky overflow flag.
// Assumes: DEPTH is a power of two; clr has priority over read and write.
module dcap_fifo #(
    parameter int W     = 20,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         not_empty,
    output logic         overflow
);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          full, push, pop, ovf_q;

    assign full = (cnt == DEPTH_C);
    assign push = wr_en && !full && !clr;
    assign pop  = rd_en && (cnt != '0) && !clr;

    // Purpose: store accepted words.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    // Purpose: track pointers, fill level and the sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
            if (wr_en && full) ovf_q <= 1'b1;
        end
    end

    assign rd_data   = mem[rp];
    assign not_empty = (cnt != '0);
    assign overflow  = ovf_q;

    a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C);
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en && !clr) |=> (cnt == DEPTH_C && ovf_q == ($past(ovf_q) || $past(wr_en))));
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf_q));
endmodule

// File: rtl/dig_capture_chan.sv
// Top of one digitizer channel: delay line, capture sequencer, channel FIFO.
// Assumes: one sample per clock on sample_in; configuration held stable
// around a trigger; the delay tap is cfg_delay registers behind the input stage.
module dig_capture_chan
    import dcap_pkg::*;
#(
    parameter int                  DELAY_MAX  = 128,
    parameter int                  FIFO_DEPTH = 64,
    parameter logic [SAMPLE_W-1:0] DEF_THRESH = 10'd8,
    localparam int                 DSEL_W     = $clog2(DELAY_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                trig,
    input  logic [DSEL_W-1:0]   cfg_delay,
    input  logic [IDX_W-1:0]    cfg_count,
    input  logic                thr_wr,
    input  logic [SAMPLE_W-1:0] thr_data,
    input  logic                thr_reset,
    input  logic                fifo_reset,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                busy,
    output logic                done,
    output logic                overflow
);
    logic [SAMPLE_W-1:0] smp_dly;
    logic                wr_en;
    cap_word_t           wr_word;

    dcap_delay #(.W(SAMPLE_W), .DEPTH(DELAY_MAX)) u_delay (
        .clk(clk), .rst_n(rst_n), .din(sample_in), .sel(cfg_delay), .dout(smp_dly)
    );

    dcap_ctrl #(.DEF_THRESH(DEF_THRESH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_count(cfg_count),
        .thr_wr(thr_wr), .thr_data(thr_data), .thr_reset(thr_reset),
        .smp_dly(smp_dly), .wr_en(wr_en), .wr_word(wr_word),
        .busy(busy), .done(done)
    );

    dcap_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_reset), .wr_en(wr_en),
        .wr_data(wr_word), .rd_en(rd_en), .rd_data(rd_data),
        .not_empty(rd_valid), .overflow(overflow)
    );
endmodule

// File: tb/test_dig_capture_chan.sv
`timescale 1ns/1ps
module test_dig_capture_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sample_in = '0;
    logic       trig = 1'b0;
    logic [6:0] cfg_delay = '0;
    logic [9:0] cfg_count = 10'd1;
    logic       thr_wr = 1'b0;
    logic [9:0] thr_data = '0;
    logic       thr_reset = 1'b0;
    logic       fifo_reset = 1'b0;
    logic       rd_en = 1'b0;
    logic [19:0] rd_data;
    logic       rd_valid, busy, done, overflow;

    int checks = 0, fails = 0;
    int mode = 0;
    int cur = 0;
    bit hold = 1'b0;
    bit finished = 1'b0;
    logic [19:0] exp_q [$];

    always #2 clk = ~clk;

    dig_capture_chan i_dig_capture_chan (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .trig(trig),
        .cfg_delay(cfg_delay), .cfg_count(cfg_count), .thr_wr(thr_wr),
        .thr_data(thr_data), .thr_reset(thr_reset), .fifo_reset(fifo_reset),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .done(done), .overflow(overflow)
    );

    function automatic logic [9:0] fsmp(int m, int n);
        case (m)
            1:       return 10'(n & 15);
            2:       return 10'(n & 1023);
            default: return 10'((n * 37 + (n >> 3) * 11) & 1023);
        endcase
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample source: value for edge number k is fsmp(mode, k).
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            sample_in = fsmp(mode, k);
            cur = k;
            k++;
        end
    end

    // Monitor: pop the scoreboard and compare each head word (R5, R11).
    initial begin
        forever begin
            @(negedge clk);
            if (!hold && rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected word", rd_data, 0);
                end else begin
                    logic [19:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R5/R1 word", rd_data, e);
                end
                rd_en = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: set up, trigger, push expected words, measure busy and done.
    task automatic run_capture(int d, int n, int thr, int m, bit retrig, int keep, string req);
        int e, bc, nn;
        mode = m;
        cfg_delay = 7'(d);
        cfg_count = 10'(n);
        nn = (n == 0) ? 1024 : n;
        wait_cyc(140);
        #1;
        trig = 1'b1;
        e = cur;
        for (int i = 0; i < nn; i++) begin
            logic [9:0] s;
            s = fsmp(m, e + i - d);
            if ((thr == 0 || s > 10'(thr)) && exp_q.size() < keep)
                exp_q.push_back({10'(i), s});
        end
        @(negedge clk);
        trig = 1'b0;
        bc = 0;
        for (int t = 0; t < 3000; t++) begin
            if (!busy) break;
            bc++;
            if (retrig) trig = (bc == nn / 2);
            @(negedge clk);
        end
        trig = 1'b0;
        chk(bc == nn, {req, " R6 busy length"}, bc, nn);
        chk(done == 1'b1, {req, " R6 done pulse"}, done, 1);
        @(negedge clk);
        chk(done == 1'b0, {req, " R6 done one clock"}, done, 0);
    endtask

    task automatic drain(string req);
        for (int t = 0; t < 3000; t++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        wait_cyc(2);
        chk(exp_q.size() == 0, {req, " R11 words missing"}, exp_q.size(), 0);
        chk(rd_valid == 1'b0, {req, " R11 no extra words"}, rd_valid, 0);
    endtask

    task automatic set_thr(int v);
        @(negedge clk); thr_wr = 1'b1; thr_data = 10'(v);
        @(negedge clk); thr_wr = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        summary();
    end

    initial begin
        wait_cyc(3);
        chk(busy == 0 && done == 0 && overflow == 0 && rd_valid == 0,
            "R12 reset state", {busy, done, overflow, rd_valid}, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(busy == 0 && rd_valid == 0 && overflow == 0,
            "R12 after release", {busy, rd_valid, overflow}, 0);

        // R4 zero threshold, short window, no delay.
        set_thr(0);
        run_capture(0, 5, 0, 0, 0, 1 << 20, "R4");
        drain("R4");
        // R1 long look-back.
        run_capture(100, 30, 0, 0, 0, 1 << 20, "R1");
        drain("R1");
        // R3 suppression with a small delay.
        set_thr(500);
        run_capture(3, 20, 500, 0, 0, 1 << 20, "R3");
        drain("R3");
        // R3 equality boundary: threshold 5, values 0..15.
        set_thr(5);
        run_capture(0, 16, 5, 1, 0, 1 << 20, "R3 equal");
        drain("R3 equal");
        // R10 default restore (8).
        @(negedge clk); thr_reset = 1'b1;
        @(negedge clk); thr_reset = 1'b0;
        run_capture(0, 32, 8, 1, 0, 1 << 20, "R10");
        drain("R10");
        // R7 trigger during capture is ignored.
        set_thr(0);
        run_capture(7, 40, 0, 0, 1, 1 << 20, "R7");
        drain("R7");
        // R2 count of zero means 1024 positions.
        set_thr(1000);
        run_capture(10, 0, 1000, 2, 0, 1 << 20, "R2");
        drain("R2");
        // R8 overflow: hold reads, 80 words into a 64-deep FIFO.
        set_thr(0);
        hold = 1'b1;
        run_capture(0, 80, 0, 0, 0, 64, "R8");
        chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
        hold = 1'b0;
        drain("R8");
        chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
        @(negedge clk); fifo_reset = 1'b1;
        @(negedge clk); fifo_reset = 1'b0;
        chk(overflow == 1'b0, "R9 overflow cleared", overflow, 0);
        // R9 contents discarded.
        hold = 1'b1;
        run_capture(0, 5, 0, 0, 0, 0, "R9");
        chk(rd_valid == 1'b1, "R9 words present", rd_valid, 1);
        @(negedge clk); fifo_reset = 1'b1;
        @(negedge clk); fifo_reset = 1'b0;
        chk(rd_valid == 1'b0, "R9 fifo emptied", rd_valid, 0);
        hold = 1'b0;
        wait_cyc(3);
        chk(rd_valid == 1'b0, "R9 stays empty", rd_valid, 0);
        summary();
    end
endmodule